// File: doc/BRIEF.md
# Bank-Resizable Issue Queue Controller

This controller keeps the bookkeeping for a circular issue queue whose entries are grouped into equal banks. Instructions are placed at the tail. They leave the queue in any order when the issue stage releases their slots. The head pointer walks forward over freed slots, so it always marks the oldest part of the occupied region. Each slot has a valid flag and an operand-ready flag. From these two flags the controller drives a per-slot enable for the wakeup tag compare. The compare is switched off for a slot that is empty or already ready.

Capacity changes at runtime in whole banks. The retire stage reports each committed instruction along with a flag that says whether it issued from the youngest bank. The youngest bank is the one that holds the most recent allocation, and the controller reports this flag at release time. The controller counts these commits over a fixed window of cycles. When the window closes, the queue gains one bank if the count reached the threshold, and loses one bank if it did not.

A bank that is being removed is closed to allocation at once. It leaves the enabled set only after its last valid slot has been released. A bank is powered when it is open to allocation or still holds valid entries.

Top module: `iq_bank_resize`

## Requirements
- R1: The dispatch slot `disp_slot` equals the tail pointer. It equals slot 0 when the tail pointer is at or beyond the allocation limit. The allocation limit is the number of banks open to allocation times `BANK_SZ`. An accepted dispatch moves the tail to the next slot, wrapping to 0 at the allocation limit. Slot s belongs to bank s / `BANK_SZ`.
- R2: `disp_stall` is high exactly when the slot at `disp_slot` holds a valid entry. A dispatch is accepted when `disp_vld` is high and `disp_stall` is low.
- R3: A release of a valid slot clears it. A release of an empty slot has no effect. A dispatch into a slot takes precedence over a release of that slot in the same cycle.
- R4: Every `INTERVAL` cycles the window closes. If the window count is at least `THRESH`, `act_banks` grows by one, up to `NBANKS`. If a removal is pending at that point, the grow decision cancels the removal instead.
- R5: If the window count is below `THRESH` when the window closes, a removal of the highest enabled bank starts. No removal starts when one is already pending or when `act_banks` is 1.
- R6: While a removal is pending, the highest enabled bank is absent from `bank_alloc_en`. `act_banks` drops by one on the first later cycle in which that bank holds no valid slot. That check is skipped in a cycle that closes a window.
- R7: The window count adds one for each cycle with `cmt_vld` and `cmt_young` both high, including the closing cycle. It restarts from zero after each window.
- R8: `cmp_en[s]` is high exactly when slot s is valid and its operand is not ready. The ready flag is loaded with `disp_src_rdy | wake_mask[s]` on dispatch and is set by `wake_mask[s]` afterwards.
- R9: `bank_pwr_on[b]` is high when bank b is open to allocation or holds at least one valid slot.
- R10: `rel_young` is high when a release hits a valid slot whose bank matches the bank of the most recent accepted dispatch (slot 0 after reset).
- R11: When the queue is empty, the head moves to the dispatch slot on the next cycle. Otherwise the head steps past an empty slot by one position per cycle, wrapping to 0 at the enabled-size boundary.
- R12: After reset, all slots are empty, head and tail are 0, `act_banks` equals `NBANKS`, no removal is pending, and the window starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_vld | input | 1 | Dispatch request |
| disp_src_rdy | input | 1 | Operand of the dispatched instruction already available |
| disp_stall | output | 1 | Dispatch target slot occupied |
| disp_slot | output | IDXW | Slot the next dispatch uses |
| rel_vld | input | 1 | Issue release request |
| rel_slot | input | IDXW | Slot being released |
| rel_young | output | 1 | Released slot lies in the youngest bank |
| wake_mask | input | NBANKS*BANK_SZ | Per-slot operand wakeup |
| cmt_vld | input | 1 | An instruction committed |
| cmt_young | input | 1 | The committed instruction issued from the youngest bank |
| bank_alloc_en | output | NBANKS | Banks open to allocation |
| bank_pwr_on | output | NBANKS | Banks that must stay powered |
| cmp_en | output | NBANKS*BANK_SZ | Per-slot wakeup compare enable |
| act_banks | output | NBW | Number of enabled banks |
| head_slot | output | IDXW | Head pointer |

## Verification
The bench first drives windows full of young commits, so the queue stays at full size. It then drives windows with none, so removals are requested while the top bank is still busy. A design that removed the bank too early would drop `act_banks` while that bank was still powered with live slots. A design that kept allocating into it would show a wrong `disp_slot`. Later phases mix rates, so that grow decisions land on pending removals and the clamp at one bank is reached. A cancel that failed would keep the bank closed. Releases of empty slots and same-slot dispatch/wake pairs are also driven. A design that mishandled them would show a `cmp_en` or `disp_stall` that disagrees with the reference model on some cycle.

// File: rtl/iqr_pkg.sv
package iqr_pkg;
    typedef enum logic [1:0] {
        DEC_HOLD   = 2'd0,
        DEC_GROW   = 2'd1,
        DEC_SHRINK = 2'd2
    } size_dec_e;

    function automatic int unsigned wrap_next(int unsigned p, int unsigned lim);
        return (p + 1 >= lim) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/iqr_entry_state.sv
module iqr_entry_state #(
    parameter int NBANKS  = 4,
    parameter int BANK_SZ = 4,
    localparam int NE     = NBANKS * BANK_SZ,
    localparam int IDXW   = $clog2(NE)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc,
    input  logic [IDXW-1:0] alloc_slot,
    input  logic            alloc_rdy,
    input  logic            rel_vld,
    input  logic [IDXW-1:0] rel_slot,
    input  logic [NE-1:0]   wake_mask,
    output logic [NE-1:0]   valid,
    output logic [NE-1:0]   cmp_en,
    output logic [NBANKS-1:0] bank_occ,
    output logic            rel_hit
);
    logic [NE-1:0] rdy;

    assign rel_hit = rel_vld && valid[rel_slot];

    for (genvar s = 0; s < NE; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid[s] <= 1'b0;
                rdy[s]   <= 1'b0;
            end else if (alloc && alloc_slot == IDXW'(s)) begin
                valid[s] <= 1'b1;
                rdy[s]   <= alloc_rdy | wake_mask[s];
            end else begin
                if (rel_vld && rel_slot == IDXW'(s)) valid[s] <= 1'b0;
                if (wake_mask[s]) rdy[s] <= 1'b1;
            end
        end
        assign cmp_en[s] = valid[s] & ~rdy[s];
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign bank_occ[b] = |valid[b*BANK_SZ +: BANK_SZ];
    end
endmodule

// File: rtl/iqr_pointers.sv
module iqr_pointers #(
    parameter int NBANKS  = 4,
    parameter int BANK_SZ = 4,
    localparam int NE     = NBANKS * BANK_SZ,
    localparam int IDXW   = $clog2(NE),
    localparam int LW     = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NE-1:0]   valid,
    input  logic [LW-1:0]   alloc_lim,
    input  logic [LW-1:0]   en_lim,
    input  logic            disp_vld,
    input  logic            q_empty,
    output logic [IDXW-1:0] target,
    output logic            stall,
    output logic            alloc,
    output logic [IDXW-1:0] head,
    output logic [IDXW-1:0] last
);
    import iqr_pkg::*;

    logic [IDXW-1:0] tail;

    assign target = (LW'(tail) >= alloc_lim) ? '0 : tail;
    assign stall  = valid[target];
    assign alloc  = disp_vld && !stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            tail <= '0;
            head <= '0;
            last <= '0;
        end else begin
            if (alloc) begin
                tail <= IDXW'(wrap_next(int'(target), int'(alloc_lim)));
                last <= target;
            end
            if (q_empty)
                head <= target;
            else if (!valid[head])
                head <= IDXW'(wrap_next(int'(head), int'(en_lim)));
        end
    end
endmodule

// File: rtl/iqr_size_ctl.sv
module iqr_size_ctl #(
    parameter int NBANKS   = 4,
    parameter int INTERVAL = 64,
    parameter int THRESH   = 8,
    localparam int NBW     = $clog2(NBANKS + 1),
    localparam int CW      = $clog2(INTERVAL + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmt_vld,
    input  logic           cmt_young,
    input  logic           top_empty,
    output logic [NBW-1:0] nb,
    output logic           pend
);
    import iqr_pkg::*;

    logic [CW-1:0] cyc;
    logic [CW-1:0] ycnt;
    logic [CW-1:0] ysum;
    logic          win_end;
    size_dec_e     dec;

    assign win_end = (cyc == CW'(INTERVAL - 1));
    assign ysum    = ycnt + CW'(cmt_vld && cmt_young);

    always_comb begin
        dec = DEC_HOLD;
        if (win_end) dec = (ysum < CW'(THRESH)) ? DEC_SHRINK : DEC_GROW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc  <= '0;
            ycnt <= '0;
            nb   <= NBW'(NBANKS);
            pend <= 1'b0;
        end else begin
            cyc  <= win_end ? '0 : cyc + 1'b1;
            ycnt <= win_end ? '0 : ysum;
            unique case (dec)
                DEC_SHRINK: begin
                    if (!pend && nb > NBW'(1)) pend <= 1'b1;
                end
                DEC_GROW: begin
                    if (pend) pend <= 1'b0;
                    else if (nb < NBW'(NBANKS)) nb <= nb + 1'b1;
                end
                default: begin
                    if (pend && top_empty) begin
                        nb   <= nb - 1'b1;
                        pend <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/iq_bank_resize.sv
module iq_bank_resize #(
    parameter int NBANKS   = 4,
    parameter int BANK_SZ  = 4,
    parameter int INTERVAL = 64,
    parameter int THRESH   = 8,
    localparam int NE      = NBANKS * BANK_SZ,
    localparam int IDXW    = $clog2(NE),
    localparam int LW      = IDXW + 1,
    localparam int NBW     = $clog2(NBANKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_vld,
    input  logic              disp_src_rdy,
    output logic              disp_stall,
    output logic [IDXW-1:0]   disp_slot,
    input  logic              rel_vld,
    input  logic [IDXW-1:0]   rel_slot,
    output logic              rel_young,
    input  logic [NE-1:0]     wake_mask,
    input  logic              cmt_vld,
    input  logic              cmt_young,
    output logic [NBANKS-1:0] bank_alloc_en,
    output logic [NBANKS-1:0] bank_pwr_on,
    output logic [NE-1:0]     cmp_en,
    output logic [NBW-1:0]    act_banks,
    output logic [IDXW-1:0]   head_slot
);
    logic [NE-1:0]     valid;
    logic [NBANKS-1:0] bank_occ;
    logic              rel_hit;
    logic              alloc;
    logic [IDXW-1:0]   last;
    logic [NBW-1:0]    nb;
    logic              pend;
    logic [NBW-1:0]    open_banks;
    logic [LW-1:0]     alloc_lim;
    logic [LW-1:0]     en_lim;
    logic [LW-1:0]     cnt;
    logic              top_empty;

    assign open_banks = nb - NBW'(pend);
    assign alloc_lim  = LW'(open_banks) * LW'(BANK_SZ);
    assign en_lim     = LW'(nb) * LW'(BANK_SZ);
    assign top_empty  = !bank_occ[nb - 1'b1];

    iqr_entry_state #(.NBANKS(NBANKS), .BANK_SZ(BANK_SZ)) u_state (
        .clk(clk), .rst(rst),
        .alloc(alloc), .alloc_slot(disp_slot), .alloc_rdy(disp_src_rdy),
        .rel_vld(rel_vld), .rel_slot(rel_slot), .wake_mask(wake_mask),
        .valid(valid), .cmp_en(cmp_en), .bank_occ(bank_occ), .rel_hit(rel_hit)
    );

    iqr_pointers #(.NBANKS(NBANKS), .BANK_SZ(BANK_SZ)) u_ptr (
        .clk(clk), .rst(rst),
        .valid(valid), .alloc_lim(alloc_lim), .en_lim(en_lim),
        .disp_vld(disp_vld), .q_empty(cnt == '0),
        .target(disp_slot), .stall(disp_stall), .alloc(alloc),
        .head(head_slot), .last(last)
    );

    iqr_size_ctl #(.NBANKS(NBANKS), .INTERVAL(INTERVAL), .THRESH(THRESH)) u_size (
        .clk(clk), .rst(rst),
        .cmt_vld(cmt_vld), .cmt_young(cmt_young), .top_empty(top_empty),
        .nb(nb), .pend(pend)
    );

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + LW'(alloc) - LW'(rel_hit);
    end

    assign rel_young = rel_hit && (int'(rel_slot) / BANK_SZ == int'(last) / BANK_SZ);

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign bank_alloc_en[b] = (NBW'(b) < open_banks);
        assign bank_pwr_on[b]   = bank_alloc_en[b] | bank_occ[b];
    end

    assign act_banks = nb;
endmodule

// File: rtl/iqr_checker.sv
module iqr_checker #(
    parameter int NBANKS  = 4,
    parameter int BANK_SZ = 4,
    localparam int NE     = NBANKS * BANK_SZ,
    localparam int IDXW   = $clog2(NE),
    localparam int NBW    = $clog2(NBANKS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              disp_vld,
    input logic              disp_src_rdy,
    input logic              disp_stall,
    input logic [IDXW-1:0]   disp_slot,
    input logic [NE-1:0]     wake_mask,
    input logic [NBANKS-1:0] bank_alloc_en,
    input logic [NBANKS-1:0] bank_pwr_on,
    input logic [NE-1:0]     cmp_en,
    input logic [NBW-1:0]    act_banks
);
    assert_alloc_open_bank_R1: assert property (@(posedge clk) disable iff (rst)
        (disp_vld && !disp_stall) |-> bank_alloc_en[int'(disp_slot) / BANK_SZ]);

    assert_size_clamped_R5: assert property (@(posedge clk) disable iff (rst)
        (act_banks >= NBW'(1)) && (act_banks <= NBW'(NBANKS)));

    assert_one_bank_step_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (int'(act_banks) <= int'($past(act_banks)) + 1) &&
                 (int'(act_banks) + 1 >= int'($past(act_banks))));

    assert_drop_needs_idle_bank_R6: assert property (@(posedge clk) disable iff (rst)
        (act_banks < $past(act_banks)) |-> !bank_pwr_on[act_banks]);

    assert_new_entry_compares_R8: assert property (@(posedge clk) disable iff (rst)
        (disp_vld && !disp_stall && !disp_src_rdy && !wake_mask[disp_slot])
        |=> cmp_en[$past(disp_slot)]);

    assert_compare_only_powered_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((cmp_en[(int'(disp_slot) / BANK_SZ) * BANK_SZ +: BANK_SZ] == '0) ||
                  bank_pwr_on[int'(disp_slot) / BANK_SZ]));
endmodule

bind iq_bank_resize iqr_checker #(.NBANKS(NBANKS), .BANK_SZ(BANK_SZ)) i_chk (
    .clk(clk), .rst(rst),
    .disp_vld(disp_vld), .disp_src_rdy(disp_src_rdy),
    .disp_stall(disp_stall), .disp_slot(disp_slot),
    .wake_mask(wake_mask), .bank_alloc_en(bank_alloc_en),
    .bank_pwr_on(bank_pwr_on), .cmp_en(cmp_en), .act_banks(act_banks)
);

// File: tb/test_iq_bank_resize.sv
`timescale 1ns/1ps
module test_iq_bank_resize;
    localparam int NB   = 4;
    localparam int BS   = 4;
    localparam int IV   = 16;
    localparam int TH   = 3;
    localparam int NE   = NB * BS;
    localparam int IDXW = $clog2(NE);
    localparam int NBW  = $clog2(NB + 1);

    logic clk = 0;
    logic rst = 1;
    logic disp_vld = 0, disp_src_rdy = 0, rel_vld = 0, cmt_vld = 0, cmt_young = 0;
    logic [IDXW-1:0] rel_slot = '0;
    logic [NE-1:0] wake_mask = '0;
    logic disp_stall, rel_young;
    logic [IDXW-1:0] disp_slot, head_slot;
    logic [NB-1:0] bank_alloc_en, bank_pwr_on;
    logic [NE-1:0] cmp_en;
    logic [NBW-1:0] act_banks;

    always #10 clk = ~clk;

    iq_bank_resize #(.NBANKS(NB), .BANK_SZ(BS), .INTERVAL(IV), .THRESH(TH)) i_iq_bank_resize (
        .clk(clk), .rst(rst), .disp_vld(disp_vld), .disp_src_rdy(disp_src_rdy),
        .disp_stall(disp_stall), .disp_slot(disp_slot), .rel_vld(rel_vld),
        .rel_slot(rel_slot), .rel_young(rel_young), .wake_mask(wake_mask),
        .cmt_vld(cmt_vld), .cmt_young(cmt_young), .bank_alloc_en(bank_alloc_en),
        .bank_pwr_on(bank_pwr_on), .cmp_en(cmp_en), .act_banks(act_banks),
        .head_slot(head_slot)
    );

    int checks = 0, errors = 0;
    bit m_val[NE];
    bit m_rdy[NE];
    int m_tail, m_head, m_last, m_cnt, m_nb, m_cyc, m_ycnt;
    bit m_pend;
    bit saw_min = 0, saw_regrow = 0, saw_pend = 0, saw_stall = 0, saw_cancel = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_open(); return m_nb - int'(m_pend); endfunction
    function automatic int m_target();
        return (m_tail >= m_open() * BS) ? 0 : m_tail;
    endfunction
    function automatic bit m_bank_occ(int b);
        for (int s = b * BS; s < (b + 1) * BS; s++) if (m_val[s]) return 1;
        return 0;
    endfunction

    task automatic compare();
        int tg;
        tg = m_target();
        chk("R1 disp_slot", int'(disp_slot), tg);
        chk("R2 disp_stall", int'(disp_stall), int'(m_val[tg]));
        chk("R11 head_slot", int'(head_slot), m_head);
        chk("R4/R5/R7 act_banks", int'(act_banks), m_nb);
        for (int b = 0; b < NB; b++) begin
            chk("R6 bank_alloc_en", int'(bank_alloc_en[b]), int'(b < m_open()));
            chk("R9 bank_pwr_on", int'(bank_pwr_on[b]), int'(b < m_open() || m_bank_occ(b)));
        end
        for (int s = 0; s < NE; s++)
            chk("R3/R8 cmp_en", int'(cmp_en[s]), int'(m_val[s] && !m_rdy[s]));
        chk("R10 rel_young", int'(rel_young),
            int'(rel_vld && m_val[rel_slot] && (int'(rel_slot) / BS == m_last / BS)));
    endtask

    task automatic step_model();
        int tg, ysum;
        bit alloc, hit, top_empty, vold[NE];
        tg = m_target();
        alloc = disp_vld && !m_val[tg];
        hit = rel_vld && m_val[rel_slot];
        if (m_val[tg] && disp_vld) saw_stall = 1;
        for (int s = 0; s < NE; s++) vold[s] = m_val[s];
        top_empty = !m_bank_occ(m_nb - 1);
        for (int s = 0; s < NE; s++) begin
            if (alloc && s == tg) begin
                m_val[s] = 1;
                m_rdy[s] = disp_src_rdy | wake_mask[s];
            end else begin
                if (rel_vld && s == int'(rel_slot)) m_val[s] = 0;
                if (wake_mask[s]) m_rdy[s] = 1;
            end
        end
        if (m_cnt == 0) m_head = tg;
        else if (!vold[m_head]) m_head = (m_head + 1 >= m_nb * BS) ? 0 : m_head + 1;
        if (alloc) begin
            m_tail = (tg + 1 >= m_open() * BS) ? 0 : tg + 1;
            m_last = tg;
        end
        m_cnt = m_cnt + int'(alloc) - int'(hit);
        ysum = m_ycnt + int'(cmt_vld && cmt_young);
        if (m_cyc == IV - 1) begin
            m_cyc = 0;
            m_ycnt = 0;
            if (ysum < TH) begin
                if (!m_pend && m_nb > 1) m_pend = 1;
            end else if (m_pend) begin
                m_pend = 0;
                saw_cancel = 1;
            end else if (m_nb < NB) begin
                m_nb++;
                if (saw_min) saw_regrow = 1;
            end
        end else begin
            m_cyc++;
            m_ycnt = ysum;
            if (m_pend && top_empty) begin
                m_nb--;
                m_pend = 0;
            end
        end
        if (m_pend) saw_pend = 1;
        if (m_nb == 1) saw_min = 1;
    endtask

    task automatic drive(int ph);
        disp_vld     = ($urandom % 100) < ((ph == 1) ? 35 : 60);
        disp_src_rdy = ($urandom % 3) == 0;
        rel_vld      = ($urandom % 100) < ((ph == 1) ? 80 : 50);
        rel_slot     = IDXW'($urandom % NE);
        wake_mask    = '0;
        if ($urandom % 4 == 0) wake_mask[$urandom % NE] = 1'b1;
        cmt_vld      = ($urandom % 2) == 0;
        case (ph)
            0: begin cmt_vld = 1; cmt_young = 1; end
            1: cmt_young = 0;
            2: cmt_young = ($urandom % 3) == 0;
            default: begin cmt_vld = 1; cmt_young = 1; end
        endcase
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < NE; s++) begin m_val[s] = 0; m_rdy[s] = 0; end
        m_tail = 0; m_head = 0; m_last = 0; m_cnt = 0;
        m_nb = NB; m_pend = 0; m_cyc = 0; m_ycnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk("R12 reset act_banks", int'(act_banks), NB);
        chk("R12 reset cmp_en", int'(cmp_en), 0);
        chk("R12 reset head", int'(head_slot), 0);
        chk("R12 reset slot", int'(disp_slot), 0);
        chk("R12 reset alloc_en", int'(bank_alloc_en), (1 << NB) - 1);
        // R3: release of an empty slot with no dispatch must leave everything idle
        rel_vld = 1; rel_slot = IDXW'(5);
        #1 compare();
        step_model();
        @(posedge clk);
        for (int cyc = 0; cyc < 3200; cyc++) begin
            @(negedge clk);
            drive((cyc < 400) ? 0 : (cyc < 1200) ? 1 : (cyc < 2200) ? 2 : 3);
            #1 compare();
            step_model();
        end
        @(negedge clk);
        chk("R5 reached one bank", int'(saw_min), 1);
        chk("R4 regrew after minimum", int'(saw_regrow), 1);
        chk("R6 removal pending seen", int'(saw_pend), 1);
        chk("R2 stall seen", int'(saw_stall), 1);
        chk("R4 cancel of pending removal seen", int'(saw_cancel), 1);
        chk("R4 final size", int'(act_banks), NB);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule